// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Priority Stack

This block arbitrates a small set of interrupt sources on behalf of one processor. Some sources are peripheral input lines. The others are software-settable bits held in a register. Every source has a programmable priority and a fixed vector equal to its source index. The controller raises a single request line when the best pending priority is strictly higher than the running priority. When that request is acknowledged, the running priority is saved on a LIFO stack and replaced by the priority of the source being serviced. A later end-of-interrupt write restores the saved value.

Two delivery modes exist, chosen by a control bit. In software mode the handler reads an acknowledge register to learn the vector, and that read is the acknowledge. In hardware mode the vector is presented on an output bus and the processor pulses an acknowledge input for one clock. An acknowledge always forces the request low for at least one cycle. This lets the processor see a clean edge even when a higher source is already waiting. The register interface is a simple single-cycle bus: writes take effect at the clock edge, and read data is combinational from the address.

Top module: `prio_intc`

## Requirements
- R1: `irqReq` goes high one cycle after the highest pending priority becomes strictly greater than the current priority. A pending source whose priority is 0 never causes a request.
- R2: Among pending sources with equal highest priority, the one with the lowest source index wins. Its index is the vector.
- R3: Address 4 holds the software source bits. Bit k is source NUM_PERIPH+k, and writing the register sets or clears all of them. These sources are arbitrated exactly like peripheral inputs (sources 0..NUM_PERIPH-1).
- R4: An acknowledge is accepted only while `irqReq` is high. Once accepted, `irqReq` is low in the following cycle, even if a higher-priority source is pending.
- R5: On an accepted acknowledge, the current priority is pushed onto the stack and replaced by the priority of the requested source. The current priority reads back at address 1, in bits [PRIO_W-1:0].
- R6: Any write to address 3 (end of interrupt) pops the stack top into the current priority. If the stack is empty, the current priority becomes 0.
- R7: If an acknowledge and an end-of-interrupt write occur in the same cycle, the stack is left unchanged and the current priority takes the priority of the source being serviced.
- R8: Bit 0 of the control register at address 0 selects hardware mode when set. `hwVecEn` equals that bit.
- R9: In software mode, `vecOut` is all zeros and `hwAck` has no effect. The acknowledge is a read of address 2 while `irqReq` is high.
- R10: In hardware mode, `vecOut` carries the vector of the source being requested, updated while the request is asserted. A one-cycle `hwAck` pulse is the acknowledge.
- R11: A read of address 2 returns the vector of the requested source in bits [VEC_W-1:0]. This is the same value `vecOut` shows in hardware mode.
- R12: The priority of source i is read and written at address 16+i, in bits [PRIO_W-1:0]. After reset, all priorities, the software bits, the control bit, the current priority and the request are 0, and the stack is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| periphIrq | input | NUM_PERIPH | Peripheral interrupt levels |
| regRe | input | 1 | Register read strobe |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 5 | Register address |
| regWdata | input | 16 | Register write data |
| regRdata | output | 16 | Register read data (combinational) |
| hwAck | input | 1 | Hardware-mode acknowledge pulse |
| irqReq | output | 1 | Interrupt request to the processor |
| vecOut | output | VEC_W | Vector bus (zeros in software mode) |
| hwVecEn | output | 1 | Hardware vector mode indicator |

## Verification
The bench starts with sources pending at priority zero, which shows that an unprogrammed source never requests. Equal-priority peripheral and software sources distinguish lowest-index tie breaking from a last-wins order. A higher source is made to arrive in the same cycle as an acknowledge, which separates a correct one-cycle request gap from a request that stays high. Nested acknowledges followed by extra end-of-interrupt writes exercise the push order, the pop order and the pop from an empty stack. An acknowledge and an end-of-interrupt write in the same cycle show whether the stack depth moves. Stray `hwAck` pulses in software mode show whether that input is really ignored.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 16;

  localparam logic [ADDR_W-1:0] ADDR_CTRL  = 5'd0;
  localparam logic [ADDR_W-1:0] ADDR_CUR   = 5'd1;
  localparam logic [ADDR_W-1:0] ADDR_ACK   = 5'd2;
  localparam logic [ADDR_W-1:0] ADDR_EOI   = 5'd3;
  localparam logic [ADDR_W-1:0] ADDR_SWSRC = 5'd4;
  localparam logic [ADDR_W-1:0] ADDR_PRIO  = 5'd16;

  // strobes from control to datapath
  typedef struct packed {
    logic ack;     // accepted acknowledge
    logic eoi;     // end-of-interrupt write
    logic latch;   // request will be high next cycle: capture winner
    logic wrSw;    // software source register write
    logic wrPrio;  // priority register window write
  } intcStrobes_t;
endpackage

// File: rtl/intc_ctrl.sv
module intc_ctrl
  import intc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regRe,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              ctrlBit,
  input  logic              hwAck,
  input  logic              above,
  output intcStrobes_t      strb,
  output logic              irqReq,
  output logic              hwMode
);
  logic hwModeQ, irqQ;
  logic swAckRd, hwAckOk;

  assign swAckRd = regRe && (regAddr == ADDR_ACK) && !hwModeQ;
  assign hwAckOk = hwAck && hwModeQ;

  always_comb begin
    strb        = '0;
    strb.ack    = irqQ && (swAckRd || hwAckOk);
    strb.eoi    = regWe && (regAddr == ADDR_EOI);
    strb.wrSw   = regWe && (regAddr == ADDR_SWSRC);
    strb.wrPrio = regWe && (regAddr >= ADDR_PRIO);
    strb.latch  = above && !strb.ack;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hwModeQ <= 1'b0;
      irqQ    <= 1'b0;
    end else begin
      if (regWe && (regAddr == ADDR_CTRL)) hwModeQ <= ctrlBit;
      irqQ <= strb.latch;
    end
  end

  assign irqReq = irqQ;
  assign hwMode = hwModeQ;

  // an accepted acknowledge always opens a gap in the request
  assert_req_gap_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.ack |=> !irqQ);

  // a request only rises after the datapath reported a winner above current
  assert_req_rise_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqQ) |-> $past(above));
endmodule

// File: rtl/intc_datapath.sv
module intc_datapath
  import intc_pkg::*;
#(
  parameter int NUM_PERIPH  = 4,
  parameter int NUM_SW      = 4,
  parameter int PRIO_W      = 4,
  parameter int STACK_DEPTH = 8,
  localparam int NUM_SRC    = NUM_PERIPH + NUM_SW,
  localparam int VEC_W      = $clog2(NUM_SRC)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  intcStrobes_t          strb,
  input  logic [NUM_PERIPH-1:0] periphIrq,
  input  logic [ADDR_W-1:0]     regAddr,
  input  logic [DATA_W-1:0]     regWdata,
  input  logic                  hwMode,
  output logic                  above,
  output logic [DATA_W-1:0]     regRdata,
  output logic [VEC_W-1:0]      vecOut
);
  localparam int CNT_W  = $clog2(STACK_DEPTH + 1);
  localparam int SP_W   = (STACK_DEPTH > 1) ? $clog2(STACK_DEPTH) : 1;
  localparam int USED_W = (PRIO_W > NUM_SW) ? PRIO_W : NUM_SW;

  logic [PRIO_W-1:0] prioQ [NUM_SRC];
  logic [PRIO_W-1:0] stackMem [STACK_DEPTH];
  logic [NUM_SW-1:0] swQ;
  logic [NUM_SRC-1:0] pending;
  logic [PRIO_W-1:0] curPrio, latPrio, winPrio;
  logic [VEC_W-1:0]  latVec, winVec;
  logic [CNT_W-1:0]  depthCnt;
  logic [SP_W-1:0]   pushIdx, popIdx;
  logic              unusedBits;

  assign unusedBits = ^regWdata[DATA_W-1:USED_W];
  assign pending    = {swQ, periphIrq};

  // priority registers, one per source
  for (genvar g = 0; g < NUM_SRC; g++) begin : gPrio
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) prioQ[g] <= '0;
      else if (strb.wrPrio && (regAddr == ADDR_PRIO + ADDR_W'(g)))
        prioQ[g] <= regWdata[PRIO_W-1:0];
    end
  end

  // strict compare keeps the lowest index on ties
  always_comb begin
    winVec  = '0;
    winPrio = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (pending[i] && (prioQ[i] > winPrio)) begin
        winPrio = prioQ[i];
        winVec  = VEC_W'(i);
      end
    end
  end

  assign above   = winPrio > curPrio;
  assign pushIdx = SP_W'(depthCnt);
  assign popIdx  = SP_W'(depthCnt - CNT_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curPrio  <= '0;
      depthCnt <= '0;
      latPrio  <= '0;
      latVec   <= '0;
      swQ      <= '0;
    end else begin
      if (strb.ack && strb.eoi) begin
        curPrio <= latPrio;
      end else if (strb.ack) begin
        if (depthCnt < CNT_W'(STACK_DEPTH)) depthCnt <= depthCnt + CNT_W'(1);
        curPrio <= latPrio;
      end else if (strb.eoi) begin
        if (depthCnt != '0) begin
          curPrio  <= stackMem[popIdx];
          depthCnt <= depthCnt - CNT_W'(1);
        end else begin
          curPrio <= '0;
        end
      end
      if (strb.latch) begin
        latPrio <= winPrio;
        latVec  <= winVec;
      end
      if (strb.wrSw) swQ <= regWdata[NUM_SW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (strb.ack && !strb.eoi && (depthCnt < CNT_W'(STACK_DEPTH)))
      stackMem[pushIdx] <= curPrio;
  end

  always_comb begin
    regRdata = '0;
    case (regAddr)
      ADDR_CTRL:  regRdata[0]          = hwMode;
      ADDR_CUR:   regRdata[PRIO_W-1:0] = curPrio;
      ADDR_ACK:   regRdata[VEC_W-1:0]  = latVec;
      ADDR_SWSRC: regRdata[NUM_SW-1:0] = swQ;
      default: begin
        for (int i = 0; i < NUM_SRC; i++)
          if (regAddr == ADDR_PRIO + ADDR_W'(i)) regRdata[PRIO_W-1:0] = prioQ[i];
      end
    endcase
  end

  assign vecOut = hwMode ? latVec : '0;

  assert_ack_push_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.ack && !strb.eoi) |=> (curPrio == $past(latPrio)));

  assert_eoi_empty_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.eoi && !strb.ack && depthCnt == '0) |=> (curPrio == '0));

  assert_collide_depth_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.ack && strb.eoi) |=> (depthCnt == $past(depthCnt)));
endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import intc_pkg::*;
#(
  parameter int NUM_PERIPH  = 4,
  parameter int NUM_SW      = 4,
  parameter int PRIO_W      = 4,
  parameter int STACK_DEPTH = 8,
  localparam int VEC_W      = $clog2(NUM_PERIPH + NUM_SW)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_PERIPH-1:0] periphIrq,
  input  logic                  regRe,
  input  logic                  regWe,
  input  logic [ADDR_W-1:0]     regAddr,
  input  logic [DATA_W-1:0]     regWdata,
  output logic [DATA_W-1:0]     regRdata,
  input  logic                  hwAck,
  output logic                  irqReq,
  output logic [VEC_W-1:0]      vecOut,
  output logic                  hwVecEn
);
  intcStrobes_t strb;
  logic above, hwMode;

  intc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .regRe(regRe), .regWe(regWe), .regAddr(regAddr),
    .ctrlBit(regWdata[0]), .hwAck(hwAck), .above(above), .strb(strb),
    .irqReq(irqReq), .hwMode(hwMode)
  );

  intc_datapath #(
    .NUM_PERIPH(NUM_PERIPH), .NUM_SW(NUM_SW), .PRIO_W(PRIO_W), .STACK_DEPTH(STACK_DEPTH)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .periphIrq(periphIrq), .regAddr(regAddr),
    .regWdata(regWdata), .hwMode(hwMode), .above(above), .regRdata(regRdata),
    .vecOut(vecOut)
  );

  assign hwVecEn = hwMode;
endmodule

// File: tb/prio_intc_bench.sv
module prio_intc_bench;
  localparam int CLK_PERIOD  = 10;
  localparam int NP          = 4;
  localparam int NS          = 4;
  localparam int NSRC        = NP + NS;
  localparam int DEPTH       = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NP-1:0] periphIrq = '0;
  logic regRe = 1'b0, regWe = 1'b0, hwAck = 1'b0;
  logic [4:0] regAddr = '0;
  logic [15:0] regWdata = '0;
  logic [15:0] regRdata;
  logic irqReq, hwVecEn;
  logic [2:0] vecOut;

  int checks = 0;
  int errors = 0;

  // reference state
  int mPrio [NSRC];
  int mSw = 0, mCur = 0, mLatVec = 0, mLatPrio = 0, mHw = 0, mIrq = 0;
  int mStk [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  prio_intc u_prio_intc (
    .clk(clk), .rstN(rstN), .periphIrq(periphIrq), .regRe(regRe), .regWe(regWe),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata), .hwAck(hwAck),
    .irqReq(irqReq), .vecOut(vecOut), .hwVecEn(hwVecEn)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // reference model, advanced on every rising edge
  always @(posedge clk) begin : model
    int best, bp, pend, ack, eoi, above, nCur;
    if (!rstN) begin
      for (int i = 0; i < NSRC; i++) mPrio[i] = 0;
      mSw = 0; mCur = 0; mLatVec = 0; mLatPrio = 0; mHw = 0; mIrq = 0;
      mStk.delete();
    end else begin
      best = 0; bp = 0;
      for (int i = 0; i < NSRC; i++) begin
        pend = (i < NP) ? periphIrq[i] : ((mSw >> (i - NP)) & 1);
        if (pend != 0 && mPrio[i] > bp) begin bp = mPrio[i]; best = i; end
      end
      above = (bp > mCur);
      ack = mIrq && (mHw ? hwAck : (regRe && regAddr == 2));
      eoi = regWe && regAddr == 3;
      nCur = mCur;
      if (ack && eoi) nCur = mLatPrio;
      else if (ack) begin
        if (mStk.size() < DEPTH) mStk.push_back(mCur);
        nCur = mLatPrio;
      end else if (eoi) begin
        if (mStk.size() > 0) nCur = mStk.pop_back();
        else nCur = 0;
      end
      mCur = nCur;
      if (above && !ack) begin mLatVec = best; mLatPrio = bp; end
      mIrq = above && !ack;
      if (regWe) begin
        if (regAddr == 0) mHw = regWdata[0];
        if (regAddr == 4) mSw = regWdata[NS-1:0];
        if (regAddr >= 16 && regAddr < 16 + NSRC) mPrio[regAddr - 16] = regWdata[3:0];
      end
    end
  end

  // compare away from the active edge
  always @(negedge clk) begin
    int expRd;
    if (rstN) begin
      chk("R1 R2 R4 irqReq", irqReq, mIrq);
      chk("R9 R10 vecOut", vecOut, mHw ? mLatVec : 0);
      chk("R8 hwVecEn", hwVecEn, mHw);
      if (regRe) begin
        case (regAddr)
          0: begin expRd = mHw; chk("R8 ctrl read", regRdata, expRd); end
          1: begin expRd = mCur; chk("R5 R6 R7 current priority read", regRdata, expRd); end
          2: begin expRd = mLatVec; chk("R11 ack read", regRdata, expRd); end
          4: begin expRd = mSw; chk("R3 sw source read", regRdata, expRd); end
          default: begin
            expRd = (regAddr >= 16 && regAddr < 16 + NSRC) ? mPrio[regAddr - 16] : 0;
            chk("R12 priority read", regRdata, expRd);
          end
        endcase
      end
    end
  end

  task automatic cyc(int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask
  task automatic wr(int a, int d);
    regWe = 1'b1; regAddr = 5'(a); regWdata = 16'(d); cyc(); regWe = 1'b0;
  endtask
  task automatic rd(int a);
    regRe = 1'b1; regAddr = 5'(a); cyc(); regRe = 1'b0;
  endtask

  initial begin
    cyc(3);
    rstN = 1'b1;
    cyc();
    // R12 reset state
    chk("R12 reset irqReq", irqReq, 0);
    rd(0); rd(1); rd(2); rd(4);
    for (int i = 0; i < NSRC; i++) rd(16 + i);

    // R1: pending at priority zero never requests
    periphIrq = 4'b1111; cyc(3);
    chk("R1 zero priority no request", irqReq, 0);
    periphIrq = 4'b0000;

    // R2/R9: tie between sources 1 and 2, software mode
    wr(16, 3); wr(17, 5); wr(18, 5); wr(19, 7);
    periphIrq = 4'b0111; cyc(2);
    hwAck = 1'b1; cyc(); hwAck = 1'b0;           // R9 ignored in software mode
    chk("R9 hwAck ignored", irqReq, 1);
    rd(2);                                         // R11 vector 1, acknowledge
    chk("R4 gap after software ack", irqReq, 0);
    rd(1); cyc(2);
    periphIrq = 4'b1111; cyc(2);
    rd(2); rd(1);                                  // nested: stack [0,5]
    wr(3, 0); rd(1); wr(3, 0); rd(1);
    periphIrq = 4'b0000; cyc(2);
    rd(2); wr(3, 0); wr(3, 0); rd(1);              // R6 pop from empty stays 0
    chk("R6 empty pop current priority", regRdata, 0);

    // hardware mode, higher source arriving with the acknowledge
    wr(0, 1);
    periphIrq = 4'b0001; cyc(3);
    chk("R10 vector of source 0", vecOut, 0);
    periphIrq = 4'b1001; hwAck = 1'b1; cyc(); hwAck = 1'b0;
    chk("R4 gap despite higher pending", irqReq, 0);
    cyc();
    chk("R4 request returns", irqReq, 1);
    chk("R10 vector of source 3", vecOut, 3);
    // R7 collision: acknowledge plus end of interrupt
    hwAck = 1'b1; regWe = 1'b1; regAddr = 5'd3; cyc(); hwAck = 1'b0; regWe = 1'b0;
    rd(1);
    chk("R7 collision current priority", regRdata, 7);
    wr(3, 0); rd(1);
    chk("R7 stack unchanged by collision", regRdata, 0);
    periphIrq = 4'b0000; cyc(2);
    hwAck = 1'b1; cyc(); hwAck = 1'b0; wr(3, 0); cyc(2);

    // R3 software sources with a tie between sources 4 and 7
    wr(20, 9); wr(21, 9); wr(22, 2); wr(23, 9);
    wr(4, 4'b1101); rd(4); cyc(2);
    chk("R3 software source 4 wins", vecOut, 4);
    rd(2);
    hwAck = 1'b1; cyc(); hwAck = 1'b0; rd(1);
    wr(4, 0); rd(4); cyc(2);
    wr(3, 0); rd(1);
    wr(0, 0); rd(0); cyc(3);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual 1 expected 0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule